// File: doc/BRIEF.md
# DMA Transfer Count and Burst Length Unit

This block keeps the byte transfer counter of a storage bus controller and works out how many bytes each DMA burst should move. Software loads a 24-bit count one byte at a time into a written copy. A command that carries the DMA flag copies the written count into the working count that the transfer uses. A transfer command then sizes the burst. It takes the smaller of the working count and the remaining phase size. During command phase it takes the smaller of the working count and a fixed 32-byte cap. A working count of zero stands for 65536 bytes.

The burst length and the transfer direction are presented for one cycle together with a start strobe. A completion strobe from the data mover stands in for the memory transfer and the bus phase. On completion the block sets terminal count, zeroes the working count, moves the remaining size toward zero and pulses an interrupt request. A transfer issued while the external DMA enable is low waits until the enable rises.

The controller has four states:
- `ST_IDLE` accepts commands.
- `ST_WAIT_EN` holds a transfer while the enable is low.
- `ST_START` issues the burst.
- `ST_BUSY` waits for the done strobe.

Its transitions are:
- `ST_IDLE` to `ST_START` on a DMA transfer command with the enable high.
- `ST_IDLE` to `ST_WAIT_EN` on the same command with the enable low.
- `ST_WAIT_EN` to `ST_START` when the enable is high.
- `ST_START` to `ST_BUSY` always.
- `ST_BUSY` to `ST_IDLE` on `xfer_done`.

Top module: `xfer_count_unit`

## Requirements
- R1: The working count reads as written byte 0 + (byte 1 << 8) + (byte 2 << 16), where `cnt_wr_sel` 0, 1 and 2 select the low, middle and high byte.
- R2: A count byte write (`cnt_wr_sel` 0 to 2) clears `term_cnt`, and the clear is visible in the next cycle.
- R3: A count write changes only the written copy. An accepted command with `cmd_dma`=1 copies the written copy into `work_count` and sets `dma_mode`. An accepted command with `cmd_dma`=0 clears `dma_mode` and leaves `work_count` unchanged.
- R4: A working count of zero gives a burst length equal to 65536 when that is the smaller value.
- R5: While `cmd_phase`=1 the burst length is min(working count, 32).
- R6: While `cmd_phase`=0 the burst length is min(working count, |rem_size|). `burst_to_dev` is 1 when `rem_size` is negative and 0 when it is positive.
- R7: `burst_start` is high for exactly one cycle per burst, together with `burst_len` and `burst_to_dev`. The cycle after it, `term_cnt` is 0.
- R8: The cycle after `xfer_done` in `ST_BUSY`, `term_cnt`=1, `work_count`=0 and `irq`=1. `irq` is high for one cycle only.
- R9: A DMA transfer command with `dma_en`=0 issues no burst while the enable stays low. The burst starts in the cycle after `dma_en` is seen high.
- R10: On completion of a burst issued with `cmd_phase`=0, `rem_size` moves toward zero by the burst length. A burst issued with `cmd_phase`=1 leaves `rem_size` unchanged. `size_load` loads `size_in` into `rem_size`.
- R11: A command that arrives while a transfer is pending or in flight is ignored, and `dma_mode` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr_en | input | 1 | Count byte write strobe |
| cnt_wr_sel | input | 2 | Count byte select (0 low, 1 middle, 2 high) |
| cnt_wr_data | input | 8 | Count byte value |
| cmd_valid | input | 1 | Command strobe |
| cmd_dma | input | 1 | Command DMA flag |
| cmd_xfer | input | 1 | Command is a transfer request |
| cmd_phase | input | 1 | Bus is in command phase |
| dma_en | input | 1 | External DMA enable |
| size_load | input | 1 | Load the remaining phase size |
| size_in | input | 25 | Signed remaining size (negative means host to device) |
| xfer_done | input | 1 | Burst completed by the data mover |
| burst_start | output | 1 | One-cycle burst start strobe |
| burst_len | output | 25 | Burst byte length, valid with `burst_start` |
| burst_to_dev | output | 1 | Burst direction, valid with `burst_start` |
| term_cnt | output | 1 | Terminal count status |
| irq | output | 1 | One-cycle completion interrupt request |
| dma_mode | output | 1 | DMA flag of the last accepted command |
| work_count | output | 24 | Working count |
| rem_size | output | 25 | Signed remaining phase size |

## Verification
The bench targets several corner cases:
- A zero count. A design that treated zero literally would issue a zero-length burst instead of 65536.
- A burst in command phase. Without the cap the burst would take the whole count.
- A pending transfer held by a low enable. A design that ignored the enable would strobe the burst at once.
- A reload without an intervening write, showing that a start clears the terminal count left by the previous completion.
- A command that arrives mid-burst, and a non-DMA command. A wrong design would change `dma_mode` or the working count.
- Both signs of the remaining size. A sign error would give the wrong direction, or move the size away from zero.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT_EN = 2'd1,
        ST_START   = 2'd2,
        ST_BUSY    = 2'd3
    } xfer_st_e;
endpackage

// File: rtl/xfer_count_regs.sv
module xfer_count_regs #(
    parameter int CNT_W = 24
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [$clog2(CNT_W/8)-1:0]        wr_sel,
    input  logic [7:0]                        wr_data,
    input  logic                              reload,
    input  logic                              zero,
    input  logic                              start_clr,
    output logic [CNT_W-1:0]                  work_count,
    output logic                              term_cnt
);
    localparam int BYTES = CNT_W / 8;
    localparam int SEL_W = $clog2(BYTES);

    logic wr_hit;
    assign wr_hit = wr_en && (wr_sel < SEL_W'(BYTES));

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        logic [7:0] wr_q;
        logic [7:0] rd_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_q <= '0;
                rd_q <= '0;
            end else begin
                if (wr_en && wr_sel == SEL_W'(b))
                    wr_q <= wr_data;
                if (zero)
                    rd_q <= '0;
                else if (reload)
                    rd_q <= wr_q;
            end
        end
        assign work_count[b*8 +: 8] = rd_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            term_cnt <= 1'b0;
        else begin
            if (zero)
                term_cnt <= 1'b1;
            if (start_clr)
                term_cnt <= 1'b0;
            if (wr_hit)
                term_cnt <= 1'b0;
        end
    end

    // R2: count byte write clears terminal count
    a_r2_wr_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> !term_cnt);
    // R8: completion zeroes the count and sets terminal count
    a_r8_done_sets_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !wr_hit) |=> (term_cnt && work_count == '0));
    // R3: the working count moves only on reload or completion
    a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !zero) |=> $stable(work_count));
endmodule

// File: rtl/xfer_len_calc.sv
module xfer_len_calc #(
    parameter int CNT_W     = 24,
    parameter int CMD_CAP   = 32,
    parameter int ZERO_LEN  = 65536
) (
    input  logic [CNT_W-1:0]  work_count,
    input  logic [CNT_W:0]    rem_size,
    input  logic              cmd_phase,
    output logic [CNT_W:0]    len,
    output logic              to_dev
);
    localparam int LEN_W = CNT_W + 1;
    localparam logic [LEN_W-1:0] ZERO_VAL = LEN_W'(ZERO_LEN);
    localparam logic [LEN_W-1:0] CAP_VAL  = LEN_W'(CMD_CAP);

    logic [LEN_W-1:0] wc;
    logic [LEN_W-1:0] mag;
    logic [LEN_W-1:0] limit;

    always_comb begin
        to_dev = rem_size[LEN_W-1];
        wc     = (work_count == '0) ? ZERO_VAL : {1'b0, work_count};
        mag    = to_dev ? (~rem_size + 1'b1) : rem_size;
        limit  = cmd_phase ? CAP_VAL : mag;
        len    = (wc < limit) ? wc : limit;
    end

    // R5: burst never exceeds the command-phase cap
    always_comb begin
        a_r5_cmd_cap: assert (!cmd_phase || len <= CAP_VAL);
    end
    // R4: burst never exceeds the count limit of a zero count
    always_comb begin
        a_r4_zero_len: assert (work_count != '0 || len <= ZERO_VAL);
    end
endmodule

// File: rtl/xfer_ctl.sv
module xfer_ctl
    import xfer_count_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_dma,
    input  logic              cmd_xfer,
    input  logic              cmd_phase,
    input  logic              dma_en,
    input  logic              size_load,
    input  logic [CNT_W:0]    size_in,
    input  logic              xfer_done,
    input  logic [CNT_W:0]    calc_len,
    output logic              reload,
    output logic              zero,
    output logic              burst_start,
    output logic              dma_mode,
    output logic              irq,
    output logic [CNT_W:0]    rem_size
);
    localparam int SIZE_W = CNT_W + 1;

    xfer_st_e          state, state_nx;
    logic [SIZE_W-1:0] len_q;
    logic              ph_q;
    logic              cmd_ok;
    logic              start_req;

    assign cmd_ok    = cmd_valid && (state == ST_IDLE);
    assign start_req = cmd_ok && cmd_dma && cmd_xfer;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx    = state;
        burst_start = 1'b0;
        zero        = 1'b0;
        reload      = cmd_ok && cmd_dma;
        unique case (state)
            ST_IDLE: begin
                if (start_req)
                    state_nx = dma_en ? ST_START : ST_WAIT_EN;
            end
            ST_WAIT_EN: begin
                if (dma_en)
                    state_nx = ST_START;
            end
            ST_START: begin
                burst_start = 1'b1;
                state_nx    = ST_BUSY;
            end
            ST_BUSY: begin
                if (xfer_done) begin
                    zero     = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_mode <= 1'b0;
            irq      <= 1'b0;
            len_q    <= '0;
            ph_q     <= 1'b0;
            rem_size <= '0;
        end else begin
            irq <= zero;
            if (cmd_ok)
                dma_mode <= cmd_dma;
            if (burst_start) begin
                len_q <= calc_len;
                ph_q  <= cmd_phase;
            end
            if (zero && !ph_q)
                rem_size <= rem_size[SIZE_W-1] ? (rem_size + len_q) : (rem_size - len_q);
            else if (size_load)
                rem_size <= size_in;
        end
    end

    // R7: start strobe lasts a single cycle
    a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> !burst_start);
    // R9: no burst while the enable stays low
    a_r9_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_EN && !dma_en) |=> !burst_start);
    // R8: completion raises the interrupt request for one cycle
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && xfer_done) |=> (irq && state == ST_IDLE));
    // R11: commands outside idle leave the DMA mode alone
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(dma_mode));
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
    parameter int CNT_W    = 24,
    parameter int CMD_CAP  = 32,
    parameter int ZERO_LEN = 65536
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cnt_wr_en,
    input  logic [$clog2(CNT_W/8)-1:0]  cnt_wr_sel,
    input  logic [7:0]                  cnt_wr_data,
    input  logic                        cmd_valid,
    input  logic                        cmd_dma,
    input  logic                        cmd_xfer,
    input  logic                        cmd_phase,
    input  logic                        dma_en,
    input  logic                        size_load,
    input  logic [CNT_W:0]              size_in,
    input  logic                        xfer_done,
    output logic                        burst_start,
    output logic [CNT_W:0]              burst_len,
    output logic                        burst_to_dev,
    output logic                        term_cnt,
    output logic                        irq,
    output logic                        dma_mode,
    output logic [CNT_W-1:0]            work_count,
    output logic [CNT_W:0]              rem_size
);
    logic          reload;
    logic          zero;
    logic          start;
    logic [CNT_W:0] calc_len;
    logic          calc_dir;

    xfer_count_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cnt_wr_en),
        .wr_sel     (cnt_wr_sel),
        .wr_data    (cnt_wr_data),
        .reload     (reload),
        .zero       (zero),
        .start_clr  (start),
        .work_count (work_count),
        .term_cnt   (term_cnt)
    );

    xfer_len_calc #(.CNT_W(CNT_W), .CMD_CAP(CMD_CAP), .ZERO_LEN(ZERO_LEN)) u_len (
        .work_count (work_count),
        .rem_size   (rem_size),
        .cmd_phase  (cmd_phase),
        .len        (calc_len),
        .to_dev     (calc_dir)
    );

    xfer_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_dma     (cmd_dma),
        .cmd_xfer    (cmd_xfer),
        .cmd_phase   (cmd_phase),
        .dma_en      (dma_en),
        .size_load   (size_load),
        .size_in     (size_in),
        .xfer_done   (xfer_done),
        .calc_len    (calc_len),
        .reload      (reload),
        .zero        (zero),
        .burst_start (start),
        .dma_mode    (dma_mode),
        .irq         (irq),
        .rem_size    (rem_size)
    );

    assign burst_start  = start;
    assign burst_len    = start ? calc_len : '0;
    assign burst_to_dev = start && calc_dir;

    // R6: direction follows the sign of the remaining size
    a_r6_dir_sign: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> (burst_to_dev == rem_size[CNT_W]));
endmodule

// File: tb/xfer_count_unit_tb.sv
`timescale 1ns/1ps
module xfer_count_unit_tb;
    localparam int CNT_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cnt_wr_en = 1'b0;
    logic [1:0]        cnt_wr_sel = '0;
    logic [7:0]        cnt_wr_data = '0;
    logic              cmd_valid = 1'b0;
    logic              cmd_dma = 1'b0;
    logic              cmd_xfer = 1'b0;
    logic              cmd_phase = 1'b0;
    logic              dma_en = 1'b1;
    logic              size_load = 1'b0;
    logic [CNT_W:0]    size_in = '0;
    logic              xfer_done = 1'b0;
    logic              burst_start;
    logic [CNT_W:0]    burst_len;
    logic              burst_to_dev;
    logic              term_cnt;
    logic              irq;
    logic              dma_mode;
    logic [CNT_W-1:0]  work_count;
    logic [CNT_W:0]    rem_size;

    int errors = 0;
    int checks = 0;
    logic [CNT_W+1:0] exp_q[$];

    always #2.5 clk = ~clk;

    xfer_count_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_sel(cnt_wr_sel), .cnt_wr_data(cnt_wr_data),
        .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .cmd_xfer(cmd_xfer),
        .cmd_phase(cmd_phase), .dma_en(dma_en),
        .size_load(size_load), .size_in(size_in), .xfer_done(xfer_done),
        .burst_start(burst_start), .burst_len(burst_len), .burst_to_dev(burst_to_dev),
        .term_cnt(term_cnt), .irq(irq), .dma_mode(dma_mode),
        .work_count(work_count), .rem_size(rem_size)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected burst when the start strobe is seen
    always @(negedge clk) begin
        if (rst_n && burst_start) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected burst", 32'(burst_len), 32'h0);
            end else begin
                logic [CNT_W+1:0] e;
                e = exp_q.pop_front();
                check(burst_len == e[CNT_W:0], "R4/R5/R6 burst_len",
                      32'(burst_len), 32'(e[CNT_W:0]));
                check(burst_to_dev == e[CNT_W+1], "R6 burst_to_dev",
                      32'(burst_to_dev), 32'(e[CNT_W+1]));
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cnt_wr_en = 1'b1; cnt_wr_sel = sel; cnt_wr_data = val;
        @(negedge clk);
        cnt_wr_en = 1'b0;
    endtask

    task automatic load_size(input logic [CNT_W:0] v);
        @(negedge clk);
        size_load = 1'b1; size_in = v;
        @(negedge clk);
        size_load = 1'b0;
    endtask

    task automatic issue(input bit dma, input bit xfer);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_dma = dma; cmd_xfer = xfer;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_dma = 1'b0; cmd_xfer = 1'b0;
    endtask

    task automatic push_exp(input logic [CNT_W:0] len, input bit dir);
        exp_q.push_back({dir, len});
    endtask

    // called in the start cycle; checks R7, completes the burst, checks R8
    task automatic finish(input logic [CNT_W:0] exp_rem);
        @(negedge clk);
        check(term_cnt == 1'b0, "R7 term_cnt cleared at start", 32'(term_cnt), 32'h0);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        check(term_cnt == 1'b1, "R8 term_cnt set", 32'(term_cnt), 32'h1);
        check(work_count == '0, "R8 work_count zeroed", 32'(work_count), 32'h0);
        check(irq == 1'b1, "R8 irq raised", 32'(irq), 32'h1);
        check(rem_size == exp_rem, "R10 rem_size", 32'(rem_size), 32'(exp_rem));
        @(negedge clk);
        check(irq == 1'b0, "R8 irq one cycle", 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(work_count == '0 && term_cnt == 1'b0 && irq == 1'b0 && dma_mode == 1'b0
              && burst_start == 1'b0 && rem_size == '0, "reset state",
              {work_count[7:0], 4'h0, term_cnt, irq, dma_mode, burst_start}, 32'h0);

        // data phase, host to device, size smaller than count
        wr(2'd0, 8'h34); wr(2'd1, 8'h12); wr(2'd2, 8'h00);
        check(work_count == '0, "R3 write leaves working count", 32'(work_count), 32'h0);
        load_size(25'(-100));
        check(rem_size == 25'(-100), "R10 size load", 32'(rem_size), 32'(25'(-100)));
        push_exp(25'd100, 1'b1);
        issue(1'b1, 1'b1);
        check(work_count == 24'h001234, "R1 count assembly", 32'(work_count), 32'h1234);
        check(dma_mode == 1'b1, "R3 dma_mode set", 32'(dma_mode), 32'h1);
        finish('0);

        // R2: byte write clears terminal count
        wr(2'd0, 8'h10);
        check(term_cnt == 1'b0, "R2 write clears term_cnt", 32'(term_cnt), 32'h0);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        load_size(25'd1000);
        push_exp(25'd16, 1'b0);
        issue(1'b1, 1'b1);
        // R11: non-DMA command while busy is ignored
        issue(1'b0, 1'b0);
        check(dma_mode == 1'b1, "R11 command ignored while busy", 32'(dma_mode), 32'h1);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        check(rem_size == 25'd984, "R10 size toward zero", 32'(rem_size), 32'd984);
        @(negedge clk);

        // R5: command phase cap, size unchanged
        wr(2'd0, 8'h40);
        cmd_phase = 1'b1;
        push_exp(25'd32, 1'b0);
        issue(1'b1, 1'b1);
        finish(25'd984);
        cmd_phase = 1'b0;

        // R4: zero count means 65536
        wr(2'd0, 8'h00);
        load_size(25'h20000);
        push_exp(25'd65536, 1'b0);
        issue(1'b1, 1'b1);
        finish(25'd65536);

        // R7: reload with no write; start clears terminal count left set
        check(term_cnt == 1'b1, "R7 term_cnt set before start", 32'(term_cnt), 32'h1);
        push_exp(25'd65536, 1'b0);
        issue(1'b1, 1'b1);
        finish('0);

        // R9: pending while enable low
        dma_en = 1'b0;
        wr(2'd0, 8'h05);
        load_size(25'(-3));
        push_exp(25'd3, 1'b1);
        issue(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            check(burst_start == 1'b0, "R9 no burst while disabled", 32'(burst_start), 32'h0);
            @(negedge clk);
        end
        check(exp_q.size() == 1, "R9 burst still pending", 32'(exp_q.size()), 32'h1);
        dma_en = 1'b1;
        @(negedge clk);
        check(burst_start == 1'b1, "R9 burst after enable", 32'(burst_start), 32'h1);
        finish('0);

        // R3: non-DMA command clears mode and does not reload
        wr(2'd0, 8'h77);
        issue(1'b0, 1'b1);
        @(negedge clk);
        check(dma_mode == 1'b0, "R3 dma_mode cleared", 32'(dma_mode), 32'h0);
        check(work_count == '0, "R3 no reload without flag", 32'(work_count), 32'h0);

        // R6: large count limited by size magnitude
        wr(2'd2, 8'h02);
        load_size(25'(-5000));
        push_exp(25'd5000, 1'b1);
        issue(1'b1, 1'b1);
        check(work_count == 24'h020077, "R1 high byte", 32'(work_count), 32'h020077);
        finish('0);

        check(exp_q.size() == 0, "R7 all bursts seen", 32'(exp_q.size()), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule